// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block keeps the program order of instructions in a speculative out-of-order core. Every instruction takes a slot at dispatch, and the block hands back the slot index as the instruction's destination tag. Execution units later broadcast results by tag, in any order. The buffer retires slots strictly from the oldest end, one per cycle:

- A register-writing slot updates the architectural register file.
- A store slot issues its memory write only at that moment.
- A branch slot is checked for a misprediction.

A branch whose broadcast marked it mispredicted is never retired. When it becomes the oldest slot and its result is present, the buffer drops it together with every younger slot, and raises a single-cycle flush carrying the corrected target. Stores and branches deliver their address, data or target through the same result broadcast, but nothing architectural changes until commit.

Dispatch is a valid/ready stream. Ready needs three things: the external reservation-station-free flag is high, a slot is free (or the oldest slot is retiring in the same cycle), and no flush is happening. The result broadcast has no back-pressure. The store port is a valid/ready stream. A store at the head holds its address and data stable and blocks retirement until the memory side accepts it. Register writes and the flush are plain pulses.

Top module: `inorder_retire_buf`

## Requirements
- R1: After reset the buffer is empty. The dispatch tag is 0, `disp_ready` equals `rs_free`, and `rf_we`, `st_valid` and `flush` are low.
- R2: A dispatch is taken in a cycle where `disp_valid` and `disp_ready` are both high. `disp_ready` is low whenever `rs_free` is low. Successive dispatches receive tags that count up modulo DEPTH (DEPTH is a power of two).
- R3: Once DEPTH slots are occupied, `disp_ready` is low. The exception is a cycle in which the head slot retires: then a dispatch is accepted into the freed index.
- R4: Results may arrive in any order. Nothing retires until the oldest slot's result has arrived, and retirement follows dispatch order.
- R5: `disp_kind` 0 marks a register slot. Its commit drives `rf_we` high for one cycle with `rf_addr` equal to the dispatched register number and `rf_data` equal to the broadcast value. The commit occurs in the cycle after the head slot's result is captured.
- R6: `disp_kind` 1 marks a store slot. At the head it drives `st_valid` with `st_addr` equal to the broadcast aux field and `st_data` equal to the broadcast value. It holds these stable, without any register write, until `st_ready` is high.
- R7: `disp_kind` 2 marks a branch and `disp_kind` 3 a no-operation. A branch broadcast with `res_mispred` low, and any no-operation, retires with no register write, store or flush.
- R8: A branch at the head whose broadcast had `res_mispred` high drives `flush` for exactly one cycle, with `flush_target` equal to its aux field. It and all younger slots are discarded, even those with results present. The next dispatch receives the branch's own tag.
- R9: A result broadcast during a flush cycle, or one aimed at an unoccupied slot, has no effect. A slot reallocated at that index still waits for its own result.
- R10: At most one of register write, store issue and flush occurs per cycle.
- R11: `disp_ready` is low in a flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rs_free | input | 1 | A reservation station can take the instruction |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Dispatch accepted when high with disp_valid |
| disp_kind | input | 2 | 0 register, 1 store, 2 branch, 3 no-operation |
| disp_areg | input | AREG_W | Architectural destination register |
| disp_tag | output | TAG_W | Tag assigned to the dispatch this cycle |
| res_valid | input | 1 | Result broadcast present |
| res_tag | input | TAG_W | Slot the result belongs to |
| res_value | input | DATA_W | Register result or store data |
| res_aux | input | DATA_W | Store address or branch target |
| res_mispred | input | 1 | Branch was mispredicted |
| rf_we | output | 1 | Architectural register write |
| rf_addr | output | AREG_W | Register number written |
| rf_data | output | DATA_W | Value written |
| st_valid | output | 1 | Store issued from the head |
| st_ready | input | 1 | Memory accepts the store |
| st_addr | output | DATA_W | Store address |
| st_data | output | DATA_W | Store data |
| flush | output | 1 | One-cycle discard of all speculative slots |
| flush_target | output | DATA_W | Corrected fetch target |

## Verification
The main test broadcasts results in reverse program order, and the scoreboard's expected commit sequence then tells in-order retirement apart from retirement by arrival. A mixed sequence of register, store, no-operation and correctly predicted branch slots separates the per-kind commit actions. Filling every slot and then retiring one while dispatching one exercises the full-with-commit case and the pointer wrap. A mispredicted branch placed behind completed younger slots, with a stale broadcast and a dispatch attempt in the flush cycle, tells a true discard apart from a late or partial one.

// File: rtl/rtb_pkg.sv
package rtb_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_NOP    = 2'd3
  } kind_e;
endpackage

// File: rtl/rtb_ptrs.sv
// Head/tail pointers with one extra wrap bit each so full and empty differ.
module rtb_ptrs #(
  parameter int DEPTH = 8,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [TAG_W-1:0] head_idx,
  output logic [TAG_W-1:0] tail_idx,
  output logic             full
);
  localparam int PW = TAG_W + 1;

  logic [PW-1:0] head_q, tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush) begin
      tail_q <= head_q;
    end else begin
      if (push) tail_q <= tail_q + PW'(1);
      if (pop)  head_q <= head_q + PW'(1);
    end
  end

  assign head_idx = head_q[TAG_W-1:0];
  assign tail_idx = tail_q[TAG_W-1:0];
  assign full     = (head_idx == tail_idx) && (head_q[PW-1] != tail_q[PW-1]);
endmodule

// File: rtl/rtb_entries.sv
// Slot storage: allocation at the tail, result capture by tag, head readout.
module rtb_entries
  import rtb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int AREG_W = 5,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [TAG_W-1:0]  alloc_idx,
  input  kind_e             alloc_kind,
  input  logic [AREG_W-1:0] alloc_areg,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_value,
  input  logic [DATA_W-1:0] res_aux,
  input  logic              res_mispred,
  input  logic              retire,
  input  logic              flush,
  input  logic [TAG_W-1:0]  head_idx,
  output logic              head_busy,
  output logic              head_ready,
  output kind_e             head_kind,
  output logic [AREG_W-1:0] head_areg,
  output logic [DATA_W-1:0] head_value,
  output logic [DATA_W-1:0] head_aux,
  output logic              head_mispred
);
  logic [DEPTH-1:0]  busy, rdy, mis;
  kind_e             kind_a  [DEPTH];
  logic [AREG_W-1:0] areg_a  [DEPTH];
  logic [DATA_W-1:0] value_a [DEPTH];
  logic [DATA_W-1:0] aux_a   [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              hit_alloc, hit_res, hit_ret;
    logic              busy_q, rdy_q, mis_q;
    kind_e             kind_q;
    logic [AREG_W-1:0] areg_q;
    logic [DATA_W-1:0] value_q, aux_q;

    assign hit_alloc = alloc && (alloc_idx == TAG_W'(i));
    // a result only lands in an occupied slot that is not being discarded
    assign hit_res   = res_valid && (res_tag == TAG_W'(i)) && busy_q && !flush;
    assign hit_ret   = retire && (head_idx == TAG_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        rdy_q  <= 1'b0;
      end else if (flush) begin
        busy_q <= 1'b0;
        rdy_q  <= 1'b0;
      end else if (hit_alloc) begin
        busy_q <= 1'b1;
        rdy_q  <= 1'b0;
      end else begin
        if (hit_ret) busy_q <= 1'b0;
        if (hit_res) rdy_q  <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_alloc) begin
        kind_q <= alloc_kind;
        areg_q <= alloc_areg;
      end
      if (hit_res) begin
        value_q <= res_value;
        aux_q   <= res_aux;
        mis_q   <= res_mispred;
      end
    end

    assign busy[i]    = busy_q;
    assign rdy[i]     = rdy_q;
    assign mis[i]     = mis_q;
    assign kind_a[i]  = kind_q;
    assign areg_a[i]  = areg_q;
    assign value_a[i] = value_q;
    assign aux_a[i]   = aux_q;
  end

  assign head_busy    = busy[head_idx];
  assign head_ready   = rdy[head_idx];
  assign head_mispred = mis[head_idx];
  assign head_kind    = kind_a[head_idx];
  assign head_areg    = areg_a[head_idx];
  assign head_value   = value_a[head_idx];
  assign head_aux     = aux_a[head_idx];
endmodule

// File: rtl/rtb_retire.sv
// Decides what the head slot does this cycle.
module rtb_retire
  import rtb_pkg::*;
(
  input  logic  head_busy,
  input  logic  head_ready,
  input  kind_e head_kind,
  input  logic  head_mispred,
  input  logic  st_ready,
  output logic  pop,
  output logic  rf_we,
  output logic  st_valid,
  output logic  flush
);
  always_comb begin
    pop      = 1'b0;
    rf_we    = 1'b0;
    st_valid = 1'b0;
    flush    = 1'b0;
    if (head_busy && head_ready) begin
      case (head_kind)
        KIND_REG: begin
          rf_we = 1'b1;
          pop   = 1'b1;
        end
        KIND_STORE: begin
          st_valid = 1'b1;
          pop      = st_ready;
        end
        KIND_BRANCH: begin
          if (head_mispred) flush = 1'b1;
          else              pop   = 1'b1;
        end
        default: pop = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/inorder_retire_buf.sv
module inorder_retire_buf
  import rtb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int AREG_W = 5,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rs_free,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [1:0]        disp_kind,
  input  logic [AREG_W-1:0] disp_areg,
  output logic [TAG_W-1:0]  disp_tag,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_value,
  input  logic [DATA_W-1:0] res_aux,
  input  logic              res_mispred,
  output logic              rf_we,
  output logic [AREG_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [DATA_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  output logic              flush,
  output logic [DATA_W-1:0] flush_target
);
  logic              pop, push, full;
  logic [TAG_W-1:0]  head_idx, tail_idx;
  logic              head_busy, head_ready, head_mispred;
  kind_e             head_kind;
  logic [AREG_W-1:0] head_areg;
  logic [DATA_W-1:0] head_value, head_aux;

  // a full buffer still accepts when the head leaves in the same cycle
  assign disp_ready = rs_free && !flush && (!full || pop);
  assign push       = disp_valid && disp_ready;
  assign disp_tag   = tail_idx;

  rtb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .flush    (flush),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .full     (full)
  );

  rtb_entries #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AREG_W(AREG_W)) u_entries (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc        (push),
    .alloc_idx    (tail_idx),
    .alloc_kind   (kind_e'(disp_kind)),
    .alloc_areg   (disp_areg),
    .res_valid    (res_valid),
    .res_tag      (res_tag),
    .res_value    (res_value),
    .res_aux      (res_aux),
    .res_mispred  (res_mispred),
    .retire       (pop),
    .flush        (flush),
    .head_idx     (head_idx),
    .head_busy    (head_busy),
    .head_ready   (head_ready),
    .head_kind    (head_kind),
    .head_areg    (head_areg),
    .head_value   (head_value),
    .head_aux     (head_aux),
    .head_mispred (head_mispred)
  );

  rtb_retire u_retire (
    .head_busy    (head_busy),
    .head_ready   (head_ready),
    .head_kind    (head_kind),
    .head_mispred (head_mispred),
    .st_ready     (st_ready),
    .pop          (pop),
    .rf_we        (rf_we),
    .st_valid     (st_valid),
    .flush        (flush)
  );

  assign rf_addr      = head_areg;
  assign rf_data      = head_value;
  assign st_addr      = head_aux;
  assign st_data      = head_value;
  assign flush_target = head_aux;
endmodule

// File: rtl/rtb_checker.sv
module rtb_checker #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rs_free,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic [TAG_W-1:0]  disp_tag,
  input logic              rf_we,
  input logic              st_valid,
  input logic              st_ready,
  input logic [DATA_W-1:0] st_addr,
  input logic [DATA_W-1:0] st_data,
  input logic              flush
);
  p_one_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, st_valid, flush}));

  p_flush_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  p_flush_drains_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!rf_we && !st_valid));

  p_store_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_addr) && $stable(st_data)));

  p_tag_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> (disp_tag == $past(disp_tag) + TAG_W'(1)));

  p_rs_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_free |-> !disp_ready);

  p_flush_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !disp_ready);
endmodule

bind inorder_retire_buf rtb_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rs_free    (rs_free),
  .disp_valid (disp_valid),
  .disp_ready (disp_ready),
  .disp_tag   (disp_tag),
  .rf_we      (rf_we),
  .st_valid   (st_valid),
  .st_ready   (st_ready),
  .st_addr    (st_addr),
  .st_data    (st_data),
  .flush      (flush)
);

// File: tb/inorder_retire_buf_tb.sv
`timescale 1ns/1ps
module inorder_retire_buf_tb;
  localparam int DEPTH = 8;
  localparam int DW    = 32;
  localparam int AW    = 5;
  localparam int TW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rs_free = 1'b1, disp_valid = 1'b0, res_valid = 1'b0, res_mispred = 1'b0;
  logic          st_ready = 1'b1;
  logic [1:0]    disp_kind = '0;
  logic [AW-1:0] disp_areg = '0;
  logic [TW-1:0] res_tag = '0;
  logic [DW-1:0] res_value = '0, res_aux = '0;
  logic          disp_ready, rf_we, st_valid, flush;
  logic [TW-1:0] disp_tag;
  logic [AW-1:0] rf_addr;
  logic [DW-1:0] rf_data, st_addr, st_data, flush_target;

  always #2 clk = ~clk;

  inorder_retire_buf #(.DEPTH(DEPTH), .DATA_W(DW), .AREG_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rs_free(rs_free), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .disp_kind(disp_kind), .disp_areg(disp_areg),
    .disp_tag(disp_tag), .res_valid(res_valid), .res_tag(res_tag),
    .res_value(res_value), .res_aux(res_aux), .res_mispred(res_mispred),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data), .st_valid(st_valid),
    .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data), .flush(flush),
    .flush_target(flush_target));

  typedef struct { int kind; logic [DW-1:0] a; logic [DW-1:0] d; } exp_t;
  exp_t expq[$];
  int checks = 0, fails = 0, seen = 0;
  bit running = 0, done = 0;
  logic [TW-1:0] nexttag = '0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(int kind, logic [DW-1:0] a, logic [DW-1:0] d);
    exp_t e;
    e.kind = kind; e.a = a; e.d = d;
    expq.push_back(e);
  endtask

  // monitor: compare each observed commit event against the scoreboard
  task automatic observe(int kind, logic [DW-1:0] a, logic [DW-1:0] d);
    exp_t e;
    string req;
    req = (kind == 0) ? "R5" : (kind == 1) ? "R6" : "R8";
    seen++;
    if (expq.size() == 0) begin
      chk("R4", "unexpected commit kind", kind, -1);
    end else begin
      e = expq.pop_front();
      chk(req, "commit kind", kind, e.kind);
      chk(req, "commit addr", a, e.a);
      chk(req, "commit data", d, e.d);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && running) begin
      chk("R10", "simultaneous commits", rf_we + (st_valid && st_ready) + flush <= 1, 1);
      if (rf_we) observe(0, DW'(rf_addr), rf_data);
      if (st_valid && st_ready) observe(1, st_addr, st_data);
      if (flush) observe(2, flush_target, '0);
    end
  end

  // all tasks start and end one time unit after a rising edge
  task automatic dispatch(input logic [1:0] kind, input logic [AW-1:0] areg, input string req);
    disp_valid = 1'b1; disp_kind = kind; disp_areg = areg;
    @(negedge clk);
    while (!disp_ready) @(negedge clk);
    chk(req, "dispatch tag", disp_tag, nexttag);
    nexttag = nexttag + 1'b1;
    @(posedge clk); #1;
    disp_valid = 1'b0;
  endtask

  task automatic bcast(input logic [TW-1:0] tag, input logic [DW-1:0] v,
                       input logic [DW-1:0] aux, input logic mis);
    res_valid = 1'b1; res_tag = tag; res_value = v; res_aux = aux; res_mispred = mis;
    @(posedge clk); #1;
    res_valid = 1'b0; res_mispred = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int s0;
    logic [TW-1:0] t0, tb;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "disp_ready", disp_ready, 1);
    chk("R1", "disp_tag", disp_tag, 0);
    chk("R1", "rf_we", rf_we, 0);
    chk("R1", "st_valid", st_valid, 0);
    chk("R1", "flush", flush, 0);
    @(posedge clk); #1;
    running = 1;
    // R2 reservation-station gate
    rs_free = 1'b0;
    @(negedge clk);
    chk("R2", "disp_ready with rs busy", disp_ready, 0);
    @(posedge clk); #1;
    rs_free = 1'b1;

    // R4/R5/R6/R7: mixed kinds, results in reverse order
    dispatch(2'd0, 5'd3, "R2");
    dispatch(2'd1, 5'd0, "R2");
    dispatch(2'd0, 5'd7, "R2");
    dispatch(2'd3, 5'd0, "R7");
    bcast(3'd3, 32'h0, 32'h0, 1'b0);
    bcast(3'd2, 32'hA2, 32'h0, 1'b0);
    bcast(3'd1, 32'hD1, 32'h400, 1'b0);
    idle(2);
    chk("R4", "commits before head result", seen, 0);
    expect_ev(0, 32'd3, 32'hA0);
    expect_ev(1, 32'h400, 32'hD1);
    expect_ev(0, 32'd7, 32'hA2);
    bcast(3'd0, 32'hA0, 32'h0, 1'b0);
    @(negedge clk);
    chk("R5", "rf_we one cycle after head result", rf_we, 1);
    chk("R5", "rf_addr", rf_addr, 3);
    @(posedge clk); #1;
    idle(4);
    chk("R4", "in-order drain", expq.size(), 0);

    // R3: fill, then retire-and-dispatch in one cycle
    t0 = nexttag;
    for (int i = 0; i < DEPTH; i++) dispatch(2'd0, AW'(i + 1), "R3");
    @(negedge clk);
    chk("R3", "disp_ready when full", disp_ready, 0);
    @(posedge clk); #1;
    for (int i = 0; i < DEPTH; i++) expect_ev(0, DW'(i + 1), 32'h100 + DW'(i));
    expect_ev(0, 32'd20, 32'h1FF);
    bcast(t0, 32'h100, 32'h0, 1'b0);
    disp_valid = 1'b1; disp_kind = 2'd0; disp_areg = 5'd20;
    @(negedge clk);
    chk("R3", "disp_ready full with commit", disp_ready, 1);
    chk("R3", "commit during full dispatch", rf_we, 1);
    chk("R3", "tag reuses freed index", disp_tag, t0);
    @(posedge clk); #1;
    disp_valid = 1'b0;
    nexttag = nexttag + 1'b1;
    @(negedge clk);
    chk("R3", "full again", disp_ready, 0);
    @(posedge clk); #1;
    for (int i = 1; i < DEPTH; i++) bcast(t0 + TW'(i), 32'h100 + DW'(i), 32'h0, 1'b0);
    bcast(t0, 32'h1FF, 32'h0, 1'b0);
    idle(3);
    chk("R3", "drained", expq.size(), 0);

    // R6: store back-pressure
    st_ready = 1'b0;
    t0 = nexttag;
    dispatch(2'd1, 5'd0, "R6");
    expect_ev(1, 32'h800, 32'h55);
    bcast(t0, 32'h55, 32'h800, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6", "st_valid held", st_valid, 1);
      chk("R6", "st_addr held", st_addr, 32'h800);
      chk("R6", "no rf_we for store", rf_we, 0);
      @(posedge clk); #1;
    end
    st_ready = 1'b1;
    idle(2);
    chk("R6", "store accepted", expq.size(), 0);

    // R7: correctly predicted branch retires quietly
    t0 = nexttag;
    dispatch(2'd2, 5'd0, "R7");
    dispatch(2'd0, 5'd9, "R7");
    expect_ev(0, 32'd9, 32'h99);
    bcast(t0, 32'h0, 32'h1234, 1'b0);
    bcast(t0 + 1'b1, 32'h99, 32'h0, 1'b0);
    idle(3);
    chk("R7", "only register commit", expq.size(), 0);

    // R8/R9/R11: mispredicted branch behind completed younger slots
    t0 = nexttag;
    tb = t0 + 1'b1;
    dispatch(2'd0, 5'd10, "R8");
    dispatch(2'd2, 5'd0, "R8");
    dispatch(2'd0, 5'd11, "R8");
    dispatch(2'd1, 5'd0, "R8");
    bcast(t0 + 3'd2, 32'hC2, 32'h0, 1'b0);
    bcast(t0 + 3'd3, 32'hC3, 32'h900, 1'b0);
    s0 = seen;
    idle(1);
    chk("R4", "nothing before head", seen, s0);
    expect_ev(0, 32'd10, 32'hAA);
    expect_ev(2, 32'hBEEF, 32'h0);
    bcast(t0, 32'hAA, 32'h0, 1'b0);
    bcast(tb, 32'h0, 32'hBEEF, 1'b1);
    res_valid = 1'b1; res_tag = t0 + 3'd2; res_value = 32'hDEAD;
    disp_valid = 1'b1; disp_kind = 2'd0; disp_areg = 5'd30;
    @(negedge clk);
    chk("R8", "flush raised", flush, 1);
    chk("R8", "flush_target", flush_target, 32'hBEEF);
    chk("R11", "disp_ready in flush", disp_ready, 0);
    @(posedge clk); #1;
    res_valid = 1'b0; disp_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8", "no commit after flush", rf_we | st_valid | flush, 0);
      chk("R8", "tail back at branch", disp_tag, tb);
      @(posedge clk); #1;
    end
    nexttag = tb;
    dispatch(2'd0, 5'd12, "R8");
    dispatch(2'd0, 5'd13, "R9");
    expect_ev(0, 32'd12, 32'hB1);
    bcast(tb, 32'hB1, 32'h0, 1'b0);
    @(negedge clk);
    @(posedge clk); #1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9", "stale result ignored", rf_we, 0);
      @(posedge clk); #1;
    end
    expect_ev(0, 32'd13, 32'hB2);
    bcast(tb + 1'b1, 32'hB2, 32'h0, 1'b0);
    idle(3);
    chk("R4", "scoreboard empty", expq.size(), 0);

    running = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule